// File: doc/BRIEF.md
# DMA Interrupt Mask and Aggregation Controller

This block gathers the interrupt sources of a multi-channel DMA engine into three groups: one bit per transmit channel, one bit per receive channel, and a small DMA-level group whose bit 1 is the host-error source. Each group keeps a registered raw status that follows its source levels, an enable mask, and a masked status equal to the raw status ANDed with the mask. The masks can only be changed through dedicated set and clear addresses: ones set or clear the matching mask bits, and zeros leave them alone.

All masked bits are ORed into one registered interrupt line. Software acknowledges an interrupt by writing zero to an end-of-interrupt address. This forces the line low for exactly one cycle. After that the line follows the masked status again, so a source that is still pending raises a fresh edge. A vector register packs the masked status of all three groups into one word, so a single read tells the handler which sources need service.

The register interface is a simple single-cycle bus. A write takes effect at the clock edge where it is presented. A read returns its data on the output in the cycle after it is presented.

Top module: `irq_agg`

## Requirements
- R1: After reset, every mask bit is 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: Raw status follows the source inputs one clock later. Transmit channel i is at bit i of offset 0x80, receive channel i is at bit i of offset 0xA0, and `host_err_i` is at bit 1 of offset 0xB0. Bit 0 of 0xB0 always reads 0.
- R3: A write to a mask-set address (transmit 0x88, receive 0xA8, DMA-level 0xB8) sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged. Channel i uses mask bit i. Data bits at or above the group width are ignored and always read 0.
- R4: A write to a mask-clear address (transmit 0x8C, receive 0xAC, DMA-level 0xBC) clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged. Writing all ones disables the whole group.
- R5: Masked status (transmit 0x84, receive 0xA4, DMA-level 0xB4) reads raw AND mask. Reading a group's set or clear address returns that group's current mask.
- R6: Reads have no side effect. Reading a status register twice returns the same value, and no mask changes on a read.
- R7: `irq_o` is the OR of all masked bits, delayed by one register stage. It rises and falls with the masked state one cycle later.
- R8: Writing 0 to offset 0x94 drives `irq_o` low in the next cycle only. In the cycle after that, `irq_o` is 1 again if any masked bit is still set. A nonzero write to 0x94 has no effect.
- R9: Offset 0x90 reads the packed vector. Bits [NUM_CH-1:0] hold the transmit masked status, bits [2*NUM_CH-1:NUM_CH] hold the receive masked status, and bits [2*NUM_CH+1:2*NUM_CH] hold the DMA-level masked status. All other bits read 0.
- R10: Reads of unmapped offsets return 0. Writes to raw, masked or vector offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| tx_src_i | input | NUM_CH | Transmit channel interrupt source levels |
| rx_src_i | input | NUM_CH | Receive channel interrupt source levels |
| host_err_i | input | 1 | Host-error interrupt source level |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The bench builds the block with NUM_CH=8, DATA_W=32 and ADDR_W=8. With these values the top channel is bit 7 and a data bit one place above it (bit 8) falls outside the group, which exercises the edge of the mask set. The same values place the host-error bit at bit 17 of the vector, so the packing of all three groups into one word is checked against a known constant. Eight channels also allow sparse and dense mask patterns, such as A5 and F0, which show that bits left at zero in a set or clear write keep their value.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DMA_W        = 2;
    localparam int HOST_ERR_BIT = 1;

    localparam logic [7:0] OFS_TX_RAW  = 8'h80;
    localparam logic [7:0] OFS_TX_MSK  = 8'h84;
    localparam logic [7:0] OFS_TX_SET  = 8'h88;
    localparam logic [7:0] OFS_TX_CLR  = 8'h8C;
    localparam logic [7:0] OFS_VECTOR  = 8'h90;
    localparam logic [7:0] OFS_EOI     = 8'h94;
    localparam logic [7:0] OFS_RX_RAW  = 8'hA0;
    localparam logic [7:0] OFS_RX_MSK  = 8'hA4;
    localparam logic [7:0] OFS_RX_SET  = 8'hA8;
    localparam logic [7:0] OFS_RX_CLR  = 8'hAC;
    localparam logic [7:0] OFS_DMA_RAW = 8'hB0;
    localparam logic [7:0] OFS_DMA_MSK = 8'hB4;
    localparam logic [7:0] OFS_DMA_SET = 8'hB8;
    localparam logic [7:0] OFS_DMA_CLR = 8'hBC;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TX_RAW, SEL_TX_MSK, SEL_TX_SET, SEL_TX_CLR,
        SEL_RX_RAW, SEL_RX_MSK, SEL_RX_SET, SEL_RX_CLR,
        SEL_DMA_RAW, SEL_DMA_MSK, SEL_DMA_SET, SEL_DMA_CLR,
        SEL_VECTOR, SEL_EOI
    } reg_sel_e;

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_comb begin
        sel_o = SEL_NONE;
        if      (hit(addr_i, OFS_TX_RAW))  sel_o = SEL_TX_RAW;
        else if (hit(addr_i, OFS_TX_MSK))  sel_o = SEL_TX_MSK;
        else if (hit(addr_i, OFS_TX_SET))  sel_o = SEL_TX_SET;
        else if (hit(addr_i, OFS_TX_CLR))  sel_o = SEL_TX_CLR;
        else if (hit(addr_i, OFS_RX_RAW))  sel_o = SEL_RX_RAW;
        else if (hit(addr_i, OFS_RX_MSK))  sel_o = SEL_RX_MSK;
        else if (hit(addr_i, OFS_RX_SET))  sel_o = SEL_RX_SET;
        else if (hit(addr_i, OFS_RX_CLR))  sel_o = SEL_RX_CLR;
        else if (hit(addr_i, OFS_DMA_RAW)) sel_o = SEL_DMA_RAW;
        else if (hit(addr_i, OFS_DMA_MSK)) sel_o = SEL_DMA_MSK;
        else if (hit(addr_i, OFS_DMA_SET)) sel_o = SEL_DMA_SET;
        else if (hit(addr_i, OFS_DMA_CLR)) sel_o = SEL_DMA_CLR;
        else if (hit(addr_i, OFS_VECTOR))  sel_o = SEL_VECTOR;
        else if (hit(addr_i, OFS_EOI))     sel_o = SEL_EOI;
    end

endmodule

// File: rtl/irq_agg_group.sv
module irq_agg_group #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] wbits_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] masked_o
);

    typedef struct packed {
        logic [W-1:0] raw;
        logic [W-1:0] mask;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = src_i;
        if (set_we_i) st_d.mask = st_q.mask | wbits_i;
        if (clr_we_i) st_d.mask = st_q.mask & ~wbits_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign mask_o   = st_q.mask;
    assign masked_o = st_q.raw & st_q.mask;

endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic any_i,
    input  logic eoi_i,
    output logic irq_o
);

    typedef struct packed {
        logic irq;
    } comb_state_t;

    comb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = eoi_i ? 1'b0 : any_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NUM_CH-1:0] tx_src_i,
    input  logic [NUM_CH-1:0] rx_src_i,
    input  logic              host_err_i,
    output logic              irq_o
);

    localparam int VEC_W  = 2 * NUM_CH + DMA_W;
    localparam int N_GRP  = 2;

    if (VEC_W > DATA_W) begin : g_bad_width
        $error("irq_agg: vector does not fit the data width");
    end
    if (ADDR_W < 8) begin : g_bad_addr
        $error("irq_agg: address width below 8 bits");
    end

    reg_sel_e sel;

    irq_agg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    // channel groups: index 0 = transmit, 1 = receive
    logic [N_GRP-1:0][NUM_CH-1:0] ch_src, ch_raw, ch_mask, ch_masked;
    logic [N_GRP-1:0]             ch_set, ch_clr;

    assign ch_src[0] = tx_src_i;
    assign ch_src[1] = rx_src_i;
    assign ch_set[0] = bus_wr_i && (sel == SEL_TX_SET);
    assign ch_clr[0] = bus_wr_i && (sel == SEL_TX_CLR);
    assign ch_set[1] = bus_wr_i && (sel == SEL_RX_SET);
    assign ch_clr[1] = bus_wr_i && (sel == SEL_RX_CLR);

    for (genvar g = 0; g < N_GRP; g++) begin : g_chan
        irq_agg_group #(.W(NUM_CH)) u_grp (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .src_i    (ch_src[g]),
            .set_we_i (ch_set[g]),
            .clr_we_i (ch_clr[g]),
            .wbits_i  (bus_wdata_i[NUM_CH-1:0]),
            .raw_o    (ch_raw[g]),
            .mask_o   (ch_mask[g]),
            .masked_o (ch_masked[g])
        );
    end

    logic [DMA_W-1:0] dma_src, dma_raw, dma_mask, dma_masked;

    always_comb begin
        dma_src               = '0;
        dma_src[HOST_ERR_BIT] = host_err_i;
    end

    irq_agg_group #(.W(DMA_W)) u_dma (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .src_i    (dma_src),
        .set_we_i (bus_wr_i && (sel == SEL_DMA_SET)),
        .clr_we_i (bus_wr_i && (sel == SEL_DMA_CLR)),
        .wbits_i  (bus_wdata_i[DMA_W-1:0]),
        .raw_o    (dma_raw),
        .mask_o   (dma_mask),
        .masked_o (dma_masked)
    );

    logic [NUM_CH-1:0] tx_mask, rx_mask;
    assign tx_mask = ch_mask[0];
    assign rx_mask = ch_mask[1];

    logic any_masked;
    logic eoi_hit;
    assign any_masked = (|ch_masked) | (|dma_masked);
    assign eoi_hit    = bus_wr_i && (sel == SEL_EOI) && (bus_wdata_i == '0);

    irq_agg_combine u_combine (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .any_i  (any_masked),
        .eoi_i  (eoi_hit),
        .irq_o  (irq_o)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [DATA_W-1:0] vec;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        vec = '0;
        vec[NUM_CH-1:0]          = ch_masked[0];
        vec[NUM_CH +: NUM_CH]    = ch_masked[1];
        vec[2*NUM_CH +: DMA_W]   = dma_masked;

        unique case (sel)
            SEL_TX_RAW:              rd_mux = DATA_W'(ch_raw[0]);
            SEL_TX_MSK:              rd_mux = DATA_W'(ch_masked[0]);
            SEL_TX_SET, SEL_TX_CLR:  rd_mux = DATA_W'(ch_mask[0]);
            SEL_RX_RAW:              rd_mux = DATA_W'(ch_raw[1]);
            SEL_RX_MSK:              rd_mux = DATA_W'(ch_masked[1]);
            SEL_RX_SET, SEL_RX_CLR:  rd_mux = DATA_W'(ch_mask[1]);
            SEL_DMA_RAW:             rd_mux = DATA_W'(dma_raw);
            SEL_DMA_MSK:             rd_mux = DATA_W'(dma_masked);
            SEL_DMA_SET, SEL_DMA_CLR: rd_mux = DATA_W'(dma_mask);
            SEL_VECTOR:              rd_mux = vec;
            default:                 rd_mux = '0;
        endcase

        st_d = st_q;
        if (bus_rd_i) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              irq_o,
    input logic              any_masked,
    input logic [NUM_CH-1:0] tx_mask,
    input logic [NUM_CH-1:0] rx_mask,
    input logic [DMA_W-1:0]  dma_mask
);

    logic eoi_w;
    assign eoi_w = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_EOI)) && (bus_wdata_i == '0);

    assert_mask_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_W'(OFS_TX_SET)) |=>
        ((tx_mask & $past(bus_wdata_i[NUM_CH-1:0])) == $past(bus_wdata_i[NUM_CH-1:0])));

    assert_mask_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_W'(OFS_RX_CLR)) |=>
        ((rx_mask & $past(bus_wdata_i[NUM_CH-1:0])) == '0));

    assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_wr_i |=> ($stable(tx_mask) && $stable(rx_mask) && $stable(dma_mask)));

    assert_irq_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !eoi_w |=> (irq_o == $past(any_masked)));

    assert_eoi_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoi_w |=> !irq_o);

endmodule

bind irq_agg irq_agg_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .any_masked  (any_masked),
    .tx_mask     (tx_mask),
    .rx_mask     (rx_mask),
    .dma_mask    (dma_mask)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NUM_CH-1:0] tx_src = '0, rx_src = '0;
    logic              host_err = 1'b0;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tx_src_i(tx_src), .rx_src_i(rx_src), .host_err_i(host_err), .irq_o(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        chk("R1", "irq after reset", 32'(irq), 32'h0);
        chk("R1", "rdata after reset", rdata, 32'h0);
        bus_read(8'h88, v); chk("R1", "tx mask reset", v, 32'h0);
        bus_read(8'hA8, v); chk("R1", "rx mask reset", v, 32'h0);
        bus_read(8'hB8, v); chk("R1", "dma mask reset", v, 32'h0);
    endtask

    task automatic t_raw();
        logic [DATA_W-1:0] v;
        @(negedge clk);
        tx_src = 8'hA5; rx_src = 8'h3C; host_err = 1'b1;
        tick();
        bus_read(8'h80, v); chk("R2", "tx raw", v, 32'hA5);
        bus_read(8'hA0, v); chk("R2", "rx raw", v, 32'h3C);
        bus_read(8'hB0, v); chk("R2", "dma raw host error bit1", v, 32'h2);
        chk("R7", "irq low with masks clear", 32'(irq), 32'h0);
    endtask

    task automatic t_set();
        logic [DATA_W-1:0] v;
        bus_write(8'h88, 32'h01);
        bus_read(8'h88, v); chk("R3", "set ch0", v, 32'h01);
        bus_write(8'h88, 32'h04);
        bus_read(8'h88, v); chk("R3", "set ch2 keeps ch0", v, 32'h05);
        bus_read(8'h84, v); chk("R5", "tx masked", v, 32'h05);
        bus_read(8'h8C, v); chk("R5", "clear addr reads mask", v, 32'h05);
        chk("R7", "irq high with masked bit", 32'(irq), 32'h1);
    endtask

    task automatic t_clear();
        logic [DATA_W-1:0] v;
        bus_write(8'h88, 32'hFF);
        bus_write(8'h8C, 32'h0F);
        bus_read(8'h88, v); chk("R4", "partial clear", v, 32'hF0);
        bus_write(8'h8C, 32'hFFFF_FFFF);
        bus_read(8'h88, v); chk("R4", "clear all", v, 32'h0);
        tick();
        chk("R7", "irq low after clear all", 32'(irq), 32'h0);
    endtask

    task automatic t_vector();
        logic [DATA_W-1:0] v;
        bus_write(8'h88, 32'hF0);
        bus_write(8'hA8, 32'h10);
        bus_write(8'hB8, 32'h02);
        bus_read(8'hA4, v); chk("R5", "rx masked", v, 32'h10);
        bus_read(8'hB4, v); chk("R5", "dma masked", v, 32'h02);
        bus_read(8'h90, v); chk("R9", "packed vector", v, 32'h0002_10A0);
    endtask

    task automatic t_eoi();
        chk("R7", "irq pending before eoi", 32'(irq), 32'h1);
        bus_write(8'h94, 32'h0);
        chk("R8", "irq gap after eoi", 32'(irq), 32'h0);
        tick();
        chk("R8", "irq re-asserts", 32'(irq), 32'h1);
        bus_write(8'h94, 32'h1);
        chk("R8", "nonzero eoi ignored", 32'(irq), 32'h1);
    endtask

    task automatic t_follow();
        @(negedge clk);
        tx_src = '0; rx_src = '0; host_err = 1'b0;
        tick();
        chk("R7", "irq one stage behind", 32'(irq), 32'h1);
        tick();
        chk("R7", "irq falls with sources", 32'(irq), 32'h0);
        bus_write(8'h94, 32'h0);
        chk("R8", "eoi with nothing pending", 32'(irq), 32'h0);
        tick();
        chk("R8", "stays low after gap", 32'(irq), 32'h0);
        @(negedge clk);
        tx_src = 8'hA5; rx_src = 8'h3C; host_err = 1'b1;
        tick();
    endtask

    task automatic t_noside();
        logic [DATA_W-1:0] v1, v2;
        bus_read(8'h84, v1);
        bus_read(8'h84, v2);
        chk("R6", "first masked read", v1, 32'hA0);
        chk("R6", "repeat masked read", v2, 32'hA0);
        bus_read(8'h88, v1); chk("R6", "mask kept after reads", v1, 32'hF0);
    endtask

    task automatic t_unmapped();
        logic [DATA_W-1:0] v;
        bus_read(8'h40, v); chk("R10", "unmapped read", v, 32'h0);
        bus_read(8'h98, v); chk("R10", "gap read", v, 32'h0);
        bus_write(8'h80, 32'hFF);
        bus_write(8'h84, 32'hFF);
        bus_write(8'h90, 32'hFFFF_FFFF);
        bus_write(8'hA4, 32'hFF);
        bus_read(8'h88, v); chk("R10", "tx mask after ro writes", v, 32'hF0);
        bus_read(8'hA8, v); chk("R10", "rx mask after ro writes", v, 32'h10);
        bus_read(8'h80, v); chk("R10", "raw after ro writes", v, 32'hA5);
    endtask

    task automatic t_boundary();
        logic [DATA_W-1:0] v;
        bus_write(8'h8C, 32'hFFFF_FFFF);
        bus_write(8'hAC, 32'hFFFF_FFFF);
        bus_write(8'hBC, 32'hFFFF_FFFF);
        @(negedge clk);
        tx_src = 8'h80;
        bus_write(8'h88, 32'h180);
        bus_read(8'h88, v); chk("R3", "top channel set, bit8 ignored", v, 32'h80);
        bus_read(8'h84, v); chk("R5", "top channel masked", v, 32'h80);
        chk("R7", "irq from top channel", 32'(irq), 32'h1);
        bus_write(8'h8C, 32'h80);
        bus_write(8'hB8, 32'h02);
        bus_read(8'h90, v); chk("R9", "vector host error only", v, 32'h0002_0000);
        chk("R7", "irq from host error", 32'(irq), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_raw();
        t_set();
        t_clear();
        t_vector();
        t_eoi();
        t_follow();
        t_noside();
        t_unmapped();
        t_boundary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule